// File: doc/BRIEF.md
# Slot-Timed Channel Reservation Manager

This block keeps the reservations that a burst scheduler has already accepted for one egress port, one first-in first-out queue per egress data channel, and turns them into timed switch-fabric commands. Reservations go into the queue of their channel in order of burst arrival. Each one carries the ingress channel, the slot in which the burst starts and the slot in which it ends. Because of that order, only the oldest entry of each queue can be the next one due.

A free-running control-slot counter is fed in from outside. Each time its value changes, the block walks over the queue heads, one channel per clock cycle, starting at channel 0. A head whose start slot equals the new counter value produces a connect command. A head whose end slot equals it produces a disconnect command and leaves its queue. When one head matches both, it produces two commands on consecutive cycles. Every command names the egress channel and the ingress channel. A full scan takes at most 2·NCH cycles. A counter change that arrives during a scan is taken up when the scan ends. Pushes are accepted at any time. A push into a full queue is dropped and reported.

Top module: `slot_resv_mgr`

## Requirements
- R1: After reset, cmd_valid and push_ovf are low and every queue is empty, so a slot change with no pushes produces no command.
- R2: When a queue head's start slot equals the new slot value, a command with cmd_connect=1 is issued for one cycle. Its cmd_egress is the queue index and its cmd_ingress is the stored ingress channel.
- R3: When a queue head's end slot equals the new slot value, a command with cmd_connect=0 (disconnect) is issued and that head is removed, so the next stored reservation becomes the head.
- R4: A head whose start and end slot both equal the new slot value issues its connect and then its disconnect for the same channel on the next cycle.
- R5: Within one slot change, commands come out in ascending egress channel order.
- R6: A head matching neither its start nor its end slot issues no command and stays stored.
- R7: Only queue heads are examined. A reservation behind the head is not acted on even when its slot matches.
- R8: A push into a queue holding DEPTH entries is refused. push_ovf is high for exactly the one cycle after that push, and the stored reservations stay unchanged.
- R9: No command is issued while the slot counter keeps its value, and each change is scanned only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Store a reservation this cycle |
| push_chan | input | CH_W | Egress channel (queue index, below NCH) |
| push_ingress | input | ING_W | Ingress channel of the reservation |
| push_start | input | SLOT_W | Slot in which the burst arrives |
| push_end | input | SLOT_W | Slot in which the burst ends |
| push_ovf | output | 1 | One-cycle pulse: previous push refused, queue full |
| slot_cnt | input | SLOT_W | Control-slot counter |
| cmd_valid | output | 1 | Switch command valid |
| cmd_connect | output | 1 | 1 = connect, 0 = disconnect |
| cmd_egress | output | CH_W | Egress channel of the command |
| cmd_ingress | output | ING_W | Ingress channel of the command |

## Verification
A single reservation is stepped through slots before, at, between and at the end of its window. This separates a missed connect from an early one and shows that a removed head does not come back. A head followed by an entry whose start slot matches the head's end slot shows whether only heads are looked at. Three channels due on the same slot, pushed in non-ascending order, show that commands follow channel order and not push order. A zero-length burst, a stretch where the counter holds its value, and a queue filled to capacity and then drained slot by slot check the paired commands, the absence of repeated scans, and that a refused push leaves no trace.

// File: rtl/slot_resv_mgr.sv
module slot_resv_mgr #(
  parameter int NCH    = 4,
  parameter int DEPTH  = 8,
  parameter int SLOT_W = 6,
  parameter int ING_W  = 4,
  parameter int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_valid,
  input  logic [CH_W-1:0]   push_chan,
  input  logic [ING_W-1:0]  push_ingress,
  input  logic [SLOT_W-1:0] push_start,
  input  logic [SLOT_W-1:0] push_end,
  output logic              push_ovf,
  input  logic [SLOT_W-1:0] slot_cnt,
  output logic              cmd_valid,
  output logic              cmd_connect,
  output logic [CH_W-1:0]   cmd_egress,
  output logic [ING_W-1:0]  cmd_ingress
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = ING_W + 2 * SLOT_W;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(NCH - 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0]  mem [NCH][DEPTH];
  logic [PTR_W-1:0]  rd_ptr [NCH];
  logic [PTR_W-1:0]  wr_ptr [NCH];
  logic [CNT_W-1:0]  cnt [NCH];
  logic [SLOT_W-1:0] slot_q;
  logic              busy, phase;
  logic [CH_W-1:0]   idx;

  wire              tick    = !busy && (slot_cnt != slot_q);
  wire [ENT_W-1:0]  head    = mem[idx][rd_ptr[idx]];
  wire [ING_W-1:0]  h_ing   = head[ENT_W-1 -: ING_W];
  wire [SLOT_W-1:0] h_start = head[2*SLOT_W-1 -: SLOT_W];
  wire [SLOT_W-1:0] h_end   = head[SLOT_W-1:0];
  wire              h_ok    = busy && (cnt[idx] != '0);
  wire              hit_s   = h_ok && !phase && (h_start == slot_q);
  wire              hit_e   = h_ok && (h_end == slot_q);
  wire              do_disc = hit_e && !hit_s;
  wire              push_ok = push_valid && (cnt[push_chan] != FULL_CNT);

  // scan sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      idx    <= '0;
      slot_q <= '0;
    end else if (tick) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      idx    <= '0;
      slot_q <= slot_cnt;
    end else if (busy) begin
      if (hit_s && hit_e) begin
        phase <= 1'b1;
      end else begin
        phase <= 1'b0;
        if (idx == LAST_CH) busy <= 1'b0;
        else                idx  <= idx + 1'b1;
      end
    end
  end

  // command and overflow outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_valid   <= 1'b0;
      cmd_connect <= 1'b0;
      cmd_egress  <= '0;
      cmd_ingress <= '0;
      push_ovf    <= 1'b0;
    end else begin
      cmd_valid   <= hit_s || do_disc;
      cmd_connect <= hit_s;
      cmd_egress  <= idx;
      cmd_ingress <= h_ing;
      push_ovf    <= push_valid && !push_ok;
    end
  end

  // per-channel queue pointers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        rd_ptr[c] <= '0;
        wr_ptr[c] <= '0;
        cnt[c]    <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        logic pu, po;
        pu = push_ok && (push_chan == CH_W'(c));
        po = do_disc && (idx == CH_W'(c));
        if (pu) wr_ptr[c] <= (wr_ptr[c] == LAST_PTR) ? '0 : wr_ptr[c] + 1'b1;
        if (po) rd_ptr[c] <= (rd_ptr[c] == LAST_PTR) ? '0 : rd_ptr[c] + 1'b1;
        if (pu && !po)      cnt[c] <= cnt[c] + 1'b1;
        else if (po && !pu) cnt[c] <= cnt[c] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[push_chan][wr_ptr[push_chan]] <= {push_ingress, push_start, push_end};
  end

  // checks
  logic            seen;
  logic [CH_W-1:0] last_eg;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      last_eg <= '0;
    end else if (tick) begin
      seen <= 1'b0;
    end else if (cmd_valid) begin
      seen    <= 1'b1;
      last_eg <= cmd_egress;
    end
  end

  // R9
  cmd_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !cmd_valid);

  // R8
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ovf |-> $past(push_valid));

  // R4
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_connect && phase) |=>
      (cmd_valid && !cmd_connect && cmd_egress == $past(cmd_egress)));

  // R5
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && seen) |-> (cmd_egress >= last_eg));

  // R8
  always_comb begin
    for (int c = 0; c < NCH; c++)
      depth_bound_chk: assert (!rst_n || cnt[c] <= FULL_CNT);
  end
endmodule

// File: tb/slot_resv_mgr_tb_top.sv
module slot_resv_mgr_tb_top;
  localparam int NCH = 4, DEPTH = 8, SLOT_W = 6, ING_W = 4, CH_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, push_ovf;
  logic [CH_W-1:0] push_chan = '0;
  logic [ING_W-1:0] push_ingress = '0;
  logic [SLOT_W-1:0] push_start = '0, push_end = '0, slot_cnt = '0;
  logic cmd_valid, cmd_connect;
  logic [CH_W-1:0] cmd_egress;
  logic [ING_W-1:0] cmd_ingress;

  always #2.5 clk = ~clk;

  slot_resv_mgr #(.NCH(NCH), .DEPTH(DEPTH), .SLOT_W(SLOT_W), .ING_W(ING_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_chan(push_chan),
    .push_ingress(push_ingress), .push_start(push_start), .push_end(push_end),
    .push_ovf(push_ovf), .slot_cnt(slot_cnt), .cmd_valid(cmd_valid),
    .cmd_connect(cmd_connect), .cmd_egress(cmd_egress), .cmd_ingress(cmd_ingress));

  int checks = 0, fails = 0, cyc = 0, n_log = 0, base = 0;
  int log_code [512];
  int log_cyc  [512];

  always @(posedge clk) cyc++;
  always @(negedge clk) if (rst_n && cmd_valid && n_log < 512) begin
    log_code[n_log] = int'(cmd_connect) * 256 + int'(cmd_egress) * 16 + int'(cmd_ingress);
    log_cyc[n_log]  = cyc;
    n_log++;
  end

  function automatic int cc(int conn, int eg, int ing);
    return conn * 256 + eg * 16 + ing;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic push(int ch, int ing, int s, int e, int exp_ovf, string tag);
    @(negedge clk);
    push_valid = 1'b1; push_chan = CH_W'(ch); push_ingress = ING_W'(ing);
    push_start = SLOT_W'(s); push_end = SLOT_W'(e);
    @(negedge clk);
    push_valid = 1'b0;
    chk(tag, int'(push_ovf), exp_ovf);
    @(negedge clk);
    if (exp_ovf != 0) chk({tag, " pulse width"}, int'(push_ovf), 0);
  endtask

  task automatic tick(int val);
    @(negedge clk);
    base = n_log;
    slot_cnt = SLOT_W'(val);
    repeat (2 * NCH + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cmd_valid after reset", int'(cmd_valid), 0);
    chk("R1 push_ovf after reset", int'(push_ovf), 0);
    tick(1);
    chk("R1 empty queues give no command", n_log - base, 0);
  endtask

  task automatic t_basic();
    push(1, 5, 3, 5, 0, "R8 accept");
    push(1, 6, 5, 6, 0, "R8 accept");
    tick(2);
    chk("R6 no match no command", n_log - base, 0);
    tick(3);
    chk("R2 one connect", n_log - base, 1);
    chk("R2 connect code", log_code[base], cc(1, 1, 5));
    tick(4);
    chk("R6 inside window silent", n_log - base, 0);
    tick(5);
    chk("R7 only head acted on", n_log - base, 1);
    chk("R3 disconnect code", log_code[base], cc(0, 1, 5));
    tick(6);
    chk("R3 next head after pop", n_log - base, 1);
    chk("R3 next head disconnect", log_code[base], cc(0, 1, 6));
    tick(7);
    chk("R3 popped heads not reactivated", n_log - base, 0);
  endtask

  task automatic t_order();
    push(3, 1, 10, 12, 0, "R8 accept");
    push(0, 2, 10, 11, 0, "R8 accept");
    push(2, 3, 10, 13, 0, "R8 accept");
    tick(10);
    chk("R5 three connects", n_log - base, 3);
    chk("R5 first ch0", log_code[base], cc(1, 0, 2));
    chk("R5 second ch2", log_code[base + 1], cc(1, 2, 3));
    chk("R5 third ch3", log_code[base + 2], cc(1, 3, 1));
    tick(11);
    chk("R3 ch0 release", log_code[base], cc(0, 0, 2));
    tick(12);
    chk("R3 ch3 release", log_code[base], cc(0, 3, 1));
    tick(13);
    chk("R3 ch2 release", log_code[base], cc(0, 2, 3));
    chk("R3 single release", n_log - base, 1);
  endtask

  task automatic t_same();
    push(1, 7, 14, 14, 0, "R8 accept");
    tick(14);
    chk("R4 two commands", n_log - base, 2);
    chk("R4 connect first", log_code[base], cc(1, 1, 7));
    chk("R4 disconnect second", log_code[base + 1], cc(0, 1, 7));
    chk("R4 consecutive cycles", log_cyc[base + 1] - log_cyc[base], 1);
  endtask

  task automatic t_hold();
    int b0;
    b0 = n_log;
    push(0, 3, 14, 15, 0, "R8 accept");
    repeat (30) @(negedge clk);
    chk("R9 held slot issues nothing", n_log - b0, 0);
    tick(15);
    chk("R9 one scan per change", n_log - base, 1);
    chk("R9 release only", log_code[base], cc(0, 0, 3));
  endtask

  task automatic t_full();
    for (int k = 0; k < DEPTH; k++) push(0, k, 40 + 2 * k, 41 + 2 * k, 0, "R8 accept below depth");
    push(0, 15, 56, 57, 1, "R8 overflow pulse");
    for (int k = 0; k < DEPTH; k++) begin
      tick(40 + 2 * k);
      chk("R8 stored entry connects", (n_log - base == 1) ? log_code[base] : -1, cc(1, 0, k));
      tick(41 + 2 * k);
      chk("R8 stored entry releases", (n_log - base == 1) ? log_code[base] : -1, cc(0, 0, k));
    end
    tick(56);
    chk("R8 refused entry absent", n_log - base, 0);
    tick(57);
    chk("R8 refused entry absent", n_log - base, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_same();
    t_hold();
    t_full();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule